// File: doc/BRIEF.md
# Interrupt and Status Register Unit

This unit holds the three host-visible registers that a SCSI-style controller uses to tell the host what happened: an interrupt cause register, a status register and a sequence-step register. It drives a level interrupt line to the host. Internal events from the controller's phase logic load these registers and may raise the interrupt. The host acknowledges by reading the cause register. That read clears the causes, drops the interrupt and moves the sequence step to the command-done code.

A command-completion event can arrive while an earlier interrupt has not yet been acknowledged. Such an event is not allowed to overwrite the registers the host is about to read. Instead, its status byte is held in a one-deep latch. The completion is then reported in the same cycle as the acknowledging read, so the host sees the new completion interrupt straight after clearing the old one.

The register layout is fixed at eight bits. The status register keeps the bus phase in bits [2:0]. The positions of the terminal-count bit and the interrupt bit, the command-done sequence code and the width of the completion status byte are all parameters.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset the cause, status and sequence registers read 0, `done_status` is 0, no completion is held and `irq` is low.
- R2: A host read (`host_rd_intr`) in a cycle with no event clears the cause register to 0. It also clears the terminal-count bit (status bit TC_BIT, default 4) and sets the sequence step to SEQ_DONE (default 4). Status phase bits [2:0] are kept.
- R3: A host read with no event and nothing held clears the interrupt bit (status bit INT_BIT, default 7) and drives `irq` low on the next cycle. `irq` always mirrors the interrupt bit.
- R4: A load event (`ev_load`) writes `ev_cause` to the cause register, `ev_seq` to the sequence step and `ev_stat` to every status bit except the interrupt bit. The interrupt bit of `ev_stat` is ignored. The interrupt is raised only when `ev_raise` is 1.
- R5: A bus-reset command sets the cause to 0x80 and leaves status and sequence unchanged. It raises the interrupt only when `cfg_rst_rpt_dis` is 0.
- R6: A selection to a missing target clears the status register, sets the cause to 0x20 (disconnect) and the sequence step to 0, then raises the interrupt. Status then reads 0x80.
- R7: A completion (`cmpl_valid`) that arrives with the interrupt bit clear, nothing held and no other event is reported on the next cycle. Status reads 0x93 (interrupt, terminal count, phase 3'b011), cause reads 0x10 (bus service), sequence reads 0, and `done_status` takes `cmpl_status`.
- R8: A completion that arrives while the interrupt bit is set and no read occurs is held. It leaves the three registers and `done_status` unchanged.
- R9: A host read while a completion is held reports it in place of the plain clear. The registers then read as in R7, `done_status` takes the held byte, `irq` stays high and the latch empties.
- R10: When an event coincides with a host read, the event's loads take priority over the clear. The interrupt stays set if the event raises it.
- R11: Simultaneous events resolve as missing-target selection first, then load, then bus reset. A completion in the same cycle as any of them is held, not reported.
- R12: A second completion arriving while one is held replaces the held status byte, so the newest byte is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_intr | input | 1 | One-cycle strobe: host reads the cause register |
| ev_load | input | 1 | Generic register-load event |
| ev_cause | input | 8 | Cause value for a load event |
| ev_stat | input | 8 | Status value for a load event (interrupt bit ignored) |
| ev_seq | input | 3 | Sequence step for a load event |
| ev_raise | input | 1 | Load event requests an interrupt |
| bus_rst_cmd | input | 1 | Bus-reset command event |
| cfg_rst_rpt_dis | input | 1 | Configuration bit: suppress bus-reset interrupt |
| sel_no_target | input | 1 | Selection found no target |
| cmpl_valid | input | 1 | Command-completion event |
| cmpl_status | input | CSTAT_W | Completion status byte |
| irq | output | 1 | Level interrupt to host |
| cause_q | output | 8 | Interrupt cause register |
| stat_q | output | 8 | Status register |
| seq_q | output | 3 | Sequence-step register |
| done_status | output | CSTAT_W | Status byte of the last reported completion |

## Verification
The bench builds the unit with its default parameters: interrupt bit 7, terminal-count bit 4, command-done code 4, an 8-bit completion byte and the keep-newest policy for held completions. With those values the status and cause encodings in the requirements are concrete bytes. The bench can also reach the replacement of a held completion by a later one. The keep-first variant chosen by the policy parameter is not built by the bench.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;

   localparam int REG_W = 8;
   localparam int SEQ_W = 3;

   localparam logic [REG_W-1:0] CAUSE_BRST = 8'h80;
   localparam logic [REG_W-1:0] CAUSE_DISC = 8'h20;
   localparam logic [REG_W-1:0] CAUSE_BSVC = 8'h10;

   localparam logic [2:0]       PH_STATUS  = 3'b011;
   localparam logic [SEQ_W-1:0] SEQ_ZERO   = '0;

   // One register update chosen from the competing events of a cycle
   typedef struct packed {
      logic             hit;
      logic [REG_W-1:0] cause;
      logic [REG_W-1:0] stat;
      logic             keep_stat;
      logic [SEQ_W-1:0] seq;
      logic             keep_seq;
      logic             raise;
   } upd_t;

endpackage

// File: rtl/irqstat_evsel.sv
module irqstat_evsel
   import irqstat_pkg::*;
#(
   parameter int INT_BIT = 7,
   parameter int TC_BIT  = 4
) (
   input  logic             sel_no_target,
   input  logic             ev_load,
   input  logic [REG_W-1:0] ev_cause,
   input  logic [REG_W-1:0] ev_stat,
   input  logic [SEQ_W-1:0] ev_seq,
   input  logic             ev_raise,
   input  logic             bus_rst_cmd,
   input  logic             cfg_rst_rpt_dis,
   input  logic             fire,
   output upd_t             upd,
   output logic             other_ev
);

   localparam logic [REG_W-1:0] INT_MASK = 8'h01 << INT_BIT;
   localparam logic [REG_W-1:0] TC_MASK  = 8'h01 << TC_BIT;
   localparam logic [REG_W-1:0] CMPL_STAT = TC_MASK | {5'b0, PH_STATUS};

   assign other_ev = sel_no_target | ev_load | bus_rst_cmd;

   always_comb begin
      upd           = '0;
      upd.keep_stat = 1'b1;
      upd.keep_seq  = 1'b1;
      if (sel_no_target) begin
         upd.hit       = 1'b1;
         upd.cause     = CAUSE_DISC;
         upd.stat      = '0;
         upd.keep_stat = 1'b0;
         upd.seq       = SEQ_ZERO;
         upd.keep_seq  = 1'b0;
         upd.raise     = 1'b1;
      end else if (ev_load) begin
         upd.hit       = 1'b1;
         upd.cause     = ev_cause;
         upd.stat      = ev_stat & ~INT_MASK;
         upd.keep_stat = 1'b0;
         upd.seq       = ev_seq;
         upd.keep_seq  = 1'b0;
         upd.raise     = ev_raise;
      end else if (bus_rst_cmd) begin
         upd.hit       = 1'b1;
         upd.cause     = CAUSE_BRST;
         upd.raise     = ~cfg_rst_rpt_dis;
      end else if (fire) begin
         upd.hit       = 1'b1;
         upd.cause     = CAUSE_BSVC;
         upd.stat      = CMPL_STAT;
         upd.keep_stat = 1'b0;
         upd.seq       = SEQ_ZERO;
         upd.keep_seq  = 1'b0;
         upd.raise     = 1'b1;
      end
   end

endmodule

// File: rtl/irqstat_defer.sv
module irqstat_defer #(
   parameter int CSTAT_W     = 8,
   parameter bit KEEP_NEWEST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmpl_valid,
   input  logic [CSTAT_W-1:0] cmpl_status,
   input  logic               int_q,
   input  logic               rd,
   input  logic               other_ev,
   output logic               pend_q,
   output logic               fire,
   output logic [CSTAT_W-1:0] done_q
);

   logic [CSTAT_W-1:0] held_q;
   logic               replay;
   logic               direct;
   logic               hold;
   logic               take_byte;

   assign replay = rd & pend_q & ~other_ev;
   assign direct = cmpl_valid & ~pend_q & ~other_ev & (~int_q | rd);
   assign hold   = cmpl_valid & ~direct;
   assign fire   = replay | direct;

   generate
      if (KEEP_NEWEST) begin : g_newest
         assign take_byte = hold;
      end else begin : g_first
         assign take_byte = hold & (~pend_q | replay);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         held_q <= '0;
         done_q <= '0;
      end else begin
         if (hold)
            pend_q <= 1'b1;
         else if (replay)
            pend_q <= 1'b0;
         if (take_byte)
            held_q <= cmpl_status;
         if (replay)
            done_q <= held_q;
         else if (direct)
            done_q <= cmpl_status;
      end
   end

   AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_valid && int_q && !rd) |=> pend_q);                           // R8
   AST_REPLAY_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && pend_q && !other_ev && !cmpl_valid) |=> !pend_q);            // R9
   AST_DONE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_q && !rd) |=> $stable(done_q));                                // R8

endmodule

// File: rtl/irqstat_regs.sv
module irqstat_regs
   import irqstat_pkg::*;
#(
   parameter int               INT_BIT  = 7,
   parameter int               TC_BIT   = 4,
   parameter logic [SEQ_W-1:0] SEQ_DONE = 3'd4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  upd_t             upd,
   output logic [REG_W-1:0] cause_q,
   output logic [REG_W-1:0] stat_q,
   output logic [SEQ_W-1:0] seq_q,
   output logic             irq
);

   localparam logic [REG_W-1:0] RD_CLR = (8'h01 << INT_BIT) | (8'h01 << TC_BIT);

   logic [REG_W-1:0] cause_b, stat_b, cause_n, stat_n;
   logic [SEQ_W-1:0] seq_b, seq_n;

   // Clear-on-read forms the base; an event in the same cycle overlays it
   always_comb begin
      cause_b = rd ? '0 : cause_q;
      stat_b  = rd ? (stat_q & ~RD_CLR) : stat_q;
      seq_b   = rd ? SEQ_DONE : seq_q;
      cause_n = cause_b;
      stat_n  = stat_b;
      seq_n   = seq_b;
      if (upd.hit) begin
         cause_n = upd.cause;
         if (!upd.keep_stat)
            stat_n = upd.stat;
         stat_n[INT_BIT] = stat_b[INT_BIT] | upd.raise;
         if (!upd.keep_seq)
            seq_n = upd.seq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         stat_q  <= '0;
         seq_q   <= '0;
      end else begin
         cause_q <= cause_n;
         stat_q  <= stat_n;
         seq_q   <= seq_n;
      end
   end

   assign irq = stat_q[INT_BIT];

   AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !upd.hit) |=> !irq);                                         // R3
   AST_CAUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !upd.hit) |=> (cause_q == '0 && seq_q == SEQ_DONE));         // R2
   AST_RAISE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (upd.hit && upd.raise) |=> irq);                                    // R10

endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
   import irqstat_pkg::*;
#(
   parameter int               CSTAT_W     = 8,
   parameter int               INT_BIT     = 7,
   parameter int               TC_BIT      = 4,
   parameter logic [SEQ_W-1:0] SEQ_DONE    = 3'd4,
   parameter bit               KEEP_NEWEST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_rd_intr,
   input  logic               ev_load,
   input  logic [REG_W-1:0]   ev_cause,
   input  logic [REG_W-1:0]   ev_stat,
   input  logic [SEQ_W-1:0]   ev_seq,
   input  logic               ev_raise,
   input  logic               bus_rst_cmd,
   input  logic               cfg_rst_rpt_dis,
   input  logic               sel_no_target,
   input  logic               cmpl_valid,
   input  logic [CSTAT_W-1:0] cmpl_status,
   output logic               irq,
   output logic [REG_W-1:0]   cause_q,
   output logic [REG_W-1:0]   stat_q,
   output logic [SEQ_W-1:0]   seq_q,
   output logic [CSTAT_W-1:0] done_status
);

   generate
      if (INT_BIT == TC_BIT || INT_BIT < 3 || TC_BIT < 3 ||
          INT_BIT >= REG_W || TC_BIT >= REG_W) begin : g_bad_bits
         $error("irq_stat_ctrl: status bit positions collide or overlap the phase field");
      end
      if (CSTAT_W < 1) begin : g_bad_width
         $error("irq_stat_ctrl: completion status width must be positive");
      end
   endgenerate

   upd_t upd;
   logic other_ev;
   logic fire;
   logic pend;

   irqstat_evsel #(
      .INT_BIT (INT_BIT),
      .TC_BIT  (TC_BIT)
   ) u_evsel (
      .sel_no_target   (sel_no_target),
      .ev_load         (ev_load),
      .ev_cause        (ev_cause),
      .ev_stat         (ev_stat),
      .ev_seq          (ev_seq),
      .ev_raise        (ev_raise),
      .bus_rst_cmd     (bus_rst_cmd),
      .cfg_rst_rpt_dis (cfg_rst_rpt_dis),
      .fire            (fire),
      .upd             (upd),
      .other_ev        (other_ev)
   );

   irqstat_defer #(
      .CSTAT_W     (CSTAT_W),
      .KEEP_NEWEST (KEEP_NEWEST)
   ) u_defer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmpl_valid  (cmpl_valid),
      .cmpl_status (cmpl_status),
      .int_q       (stat_q[INT_BIT]),
      .rd          (host_rd_intr),
      .other_ev    (other_ev),
      .pend_q      (pend),
      .fire        (fire),
      .done_q      (done_status)
   );

   irqstat_regs #(
      .INT_BIT  (INT_BIT),
      .TC_BIT   (TC_BIT),
      .SEQ_DONE (SEQ_DONE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (host_rd_intr),
      .upd     (upd),
      .cause_q (cause_q),
      .stat_q  (stat_q),
      .seq_q   (seq_q),
      .irq     (irq)
   );

   AST_BUSRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst_cmd && cfg_rst_rpt_dis && !sel_no_target && !ev_load && !irq)
      |=> !irq);                                                          // R5
   AST_REPLAY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_intr && pend && !other_ev) |=> irq);                       // R9
   AST_SEL_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      sel_no_target |=> (cause_q == CAUSE_DISC && irq));                  // R11

endmodule

// File: tb/test_irq_stat_ctrl.sv
module test_irq_stat_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_rd_intr = 1'b0;
   logic       ev_load = 1'b0;
   logic [7:0] ev_cause = '0;
   logic [7:0] ev_stat = '0;
   logic [2:0] ev_seq = '0;
   logic       ev_raise = 1'b0;
   logic       bus_rst_cmd = 1'b0;
   logic       cfg_rst_rpt_dis = 1'b0;
   logic       sel_no_target = 1'b0;
   logic       cmpl_valid = 1'b0;
   logic [7:0] cmpl_status = '0;
   logic       irq;
   logic [7:0] cause_q, stat_q, done_status;
   logic [2:0] seq_q;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_stat_ctrl i_irq_stat_ctrl (
      .clk (clk), .rst_n (rst_n), .host_rd_intr (host_rd_intr),
      .ev_load (ev_load), .ev_cause (ev_cause), .ev_stat (ev_stat),
      .ev_seq (ev_seq), .ev_raise (ev_raise), .bus_rst_cmd (bus_rst_cmd),
      .cfg_rst_rpt_dis (cfg_rst_rpt_dis), .sel_no_target (sel_no_target),
      .cmpl_valid (cmpl_valid), .cmpl_status (cmpl_status),
      .irq (irq), .cause_q (cause_q), .stat_q (stat_q), .seq_q (seq_q),
      .done_status (done_status)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag, input logic [7:0] c,
                           input logic [7:0] s, input logic [2:0] q,
                           input logic i);
      chk(tag, "cause", cause_q, c);
      chk(tag, "status", stat_q, s);
      chk(tag, "seq", seq_q, q);
      chk(tag, "irq", irq, i);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      host_rd_intr = 0; ev_load = 0; ev_raise = 0; bus_rst_cmd = 0;
      sel_no_target = 0; cmpl_valid = 0;
   endtask

   task automatic do_load(input logic [7:0] c, input logic [7:0] s,
                          input logic [2:0] q, input logic r);
      ev_load = 1; ev_cause = c; ev_stat = s; ev_seq = q; ev_raise = r;
   endtask

   task automatic read_once();
      host_rd_intr = 1; tick(); idle();
   endtask

   task automatic t_reset();
      chk_regs("R1", 8'h00, 8'h00, 3'd0, 1'b0);
      chk("R1", "done_status", done_status, 8'h00);
   endtask

   task automatic t_load();
      do_load(8'h08, 8'h81, 3'd2, 1'b0); tick(); idle();
      chk_regs("R4", 8'h08, 8'h01, 3'd2, 1'b0);    // bit 7 of ev_stat ignored
      do_load(8'h08, 8'h12, 3'd2, 1'b1); tick(); idle();
      chk_regs("R4", 8'h08, 8'h92, 3'd2, 1'b1);
   endtask

   task automatic t_read();
      read_once();
      chk_regs("R2", 8'h00, 8'h02, 3'd4, 1'b0);     // R3: irq dropped
      chk("R3", "int bit", stat_q[7], 1'b0);
   endtask

   task automatic t_bus_reset();
      cfg_rst_rpt_dis = 1; bus_rst_cmd = 1; tick(); idle();
      chk_regs("R5", 8'h80, 8'h02, 3'd4, 1'b0);
      read_once();
      cfg_rst_rpt_dis = 0; bus_rst_cmd = 1; tick(); idle();
      chk_regs("R5", 8'h80, 8'h82, 3'd4, 1'b1);
      read_once();
   endtask

   task automatic t_sel_missing();
      sel_no_target = 1; tick(); idle();
      chk_regs("R6", 8'h20, 8'h80, 3'd0, 1'b1);
      read_once();
      chk_regs("R3", 8'h00, 8'h00, 3'd4, 1'b0);
   endtask

   task automatic t_cmpl_direct();
      cmpl_valid = 1; cmpl_status = 8'h02; tick(); idle();
      chk_regs("R7", 8'h10, 8'h93, 3'd0, 1'b1);
      chk("R7", "done_status", done_status, 8'h02);
      read_once();
      chk_regs("R2", 8'h00, 8'h03, 3'd4, 1'b0);
   endtask

   task automatic t_defer();
      do_load(8'h08, 8'h01, 3'd1, 1'b1); tick(); idle();
      cmpl_valid = 1; cmpl_status = 8'h55; tick(); idle();
      chk_regs("R8", 8'h08, 8'h81, 3'd1, 1'b1);
      chk("R8", "done_status", done_status, 8'h02);
      cmpl_valid = 1; cmpl_status = 8'h66; tick(); idle();
      chk("R12", "done_status held", done_status, 8'h02);
      read_once();
      chk_regs("R9", 8'h10, 8'h93, 3'd0, 1'b1);
      chk("R12", "done_status newest", done_status, 8'h66);
      read_once();
      chk_regs("R9", 8'h00, 8'h03, 3'd4, 1'b0);     // latch emptied
      chk("R9", "done_status kept", done_status, 8'h66);
   endtask

   task automatic t_event_vs_read();
      do_load(8'h08, 8'h01, 3'd1, 1'b1); tick(); idle();
      host_rd_intr = 1; do_load(8'h04, 8'h02, 3'd3, 1'b1); tick(); idle();
      chk_regs("R10", 8'h04, 8'h82, 3'd3, 1'b1);
      read_once();
      chk_regs("R10", 8'h00, 8'h02, 3'd4, 1'b0);
   endtask

   task automatic t_priority();
      sel_no_target = 1; do_load(8'h01, 8'h05, 3'd2, 1'b0);
      bus_rst_cmd = 1; cmpl_valid = 1; cmpl_status = 8'h77; tick(); idle();
      chk_regs("R11", 8'h20, 8'h80, 3'd0, 1'b1);
      chk("R11", "done_status", done_status, 8'h66);
      do_load(8'h01, 8'h05, 3'd2, 1'b0); bus_rst_cmd = 1; tick(); idle();
      chk_regs("R11", 8'h01, 8'h85, 3'd2, 1'b1);
      read_once();
      chk_regs("R11", 8'h10, 8'h93, 3'd0, 1'b1);
      chk("R11", "done_status replay", done_status, 8'h77);
      read_once();
      chk_regs("R11", 8'h00, 8'h03, 3'd4, 1'b0);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) tick();
      t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_load();
      t_read();
      t_bus_reset();
      t_sel_missing();
      t_cmpl_direct();
      t_defer();
      t_event_vs_read();
      t_priority();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule